// File: doc/BRIEF.md
# USB Receive Deserializer with UTMI-Style Byte Interface

This block takes the sampled levels of a USB differential pair, one sample per cycle of a fast serial clock, and turns the incoming packets into bytes on a UTMI-style receive interface that runs on a clock one eighth as fast. The serial chain has three stages in a fixed order. First an NRZI decoder, then a bit unstuffer that also flags stuff errors, then a shift register that collects bytes least-significant bit first. A framing state machine watches the decoded stream for the end of the sync pattern and for the single-ended-zero that ends a packet. It turns what it sees into start, byte, end and error events.

The events cross into the slow domain through a small gray-pointer queue. On the slow side they drive `rx_active` (packet in progress), `rx_valid` (one cycle for each byte, with `rx_data`) and `rx_error` (stuff violation). The current line state is synchronised on its own path and reported continuously. A transceiver-select input chooses high-speed reception, with one bit on every fast clock, or full-speed reception, with one bit every `FS_DIV` fast clocks.

Top module: `usbrx_deser`

## Requirements
- R1: `line_state` reports `{line_dm, line_dp}` after two slow-clock flip-flops, so 2'b00 is SE0, 2'b01 is J (dp high), 2'b10 is K (dm high) and 2'b11 is SE1.
- R2: A received bit decodes to 1 when the sampled dp level equals the level of the previous bit and to 0 when it differs. The level before the first bit, and the level after any SE0, is taken as J.
- R3: `rx_active` rises only after a sync pattern whose decoded tail is 0,0,0,1 with the line at K (the K-J-K-J-K-J-K-K sequence). No byte is reported before that point.
- R4: Data bits are packed least-significant bit first. Each completed byte raises `rx_valid` for exactly one slow cycle, and `rx_data` holds that byte in the same cycle.
- R5: Inside a packet, the bit that follows six consecutive decoded 1s is removed and never appears in a byte. The sync pattern's final 1 counts toward those six.
- R6: If that removed bit is 1, `rx_error` pulses for one slow cycle and `rx_active` falls. No further byte is reported until an SE0 has been seen and a new sync pattern has been received.
- R7: An SE0 sample during a packet ends it. `rx_active` falls and any bits of an incomplete byte are discarded without a `rx_valid`.
- R8: With `fs_sel` = 1 the line is sampled once every `FS_DIV` fast clocks. With `fs_sel` = 0 it is sampled on every fast clock. Both modes yield the same bytes for the same packet.
- R9: Pulling `rst_n` low clears `rx_active`, `rx_valid`, `rx_error` and `line_state` at once, without waiting for a clock edge. A packet in progress is abandoned, and the next packet after release is received correctly.
- R10: `rx_valid` is never high while `rx_active` is low.
- R11: A back-to-back high-speed stream of bytes is delivered complete and in arrival order across the clock crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fclk | input | 1 | Fast serial sampling clock |
| clk | input | 1 | Slow UTMI-side clock, one eighth of fclk |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| line_dp | input | 1 | Sampled D+ level, fclk domain |
| line_dm | input | 1 | Sampled D- level, fclk domain |
| fs_sel | input | 1 | Transceiver select: 0 high speed, 1 full speed |
| rx_data | output | 8 | Received byte, valid while rx_valid is high |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| rx_active | output | 1 | High between sync detection and end of packet or error |
| rx_error | output | 1 | One-cycle strobe on a bit-stuff violation |
| line_state | output | 2 | Synchronised {dm, dp} line state |

## Verification
The bench builds the block with `FS_DIV` = 12 and leaves `FIFO_DEPTH` = 8, `STUFF_RUN` = 6 and `SYNC_ZEROS` = 3 at their defaults. A divider of 12 keeps full-speed packets short enough to send several of them. It also gives a bit period of one and a half slow cycles, so full-speed bit boundaries drift against the slow clock instead of sitting in a fixed phase. With the default queue depth, long high-speed packets run the crossing at its full rate of one byte per slow cycle, so ordering and loss under steady load are exercised.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    EV_SOP  = 2'd0,
    EV_DATA = 2'd1,
    EV_EOP  = 2'd2,
    EV_ERR  = 2'd3
  } ev_kind_e;

  typedef struct packed {
    ev_kind_e            kind;
    logic [BYTE_W-1:0]   data;
  } ev_t;

  localparam int EV_W = $bits(ev_t);

endpackage

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi #(
  parameter int FS_DIV = 40
) (
  input  logic fclk,
  input  logic frst_n,
  input  logic line_dp,
  input  logic line_dm,
  input  logic fs_sel,
  output logic o_vld,
  output logic o_bit,
  output logic o_se0,
  output logic o_k
);

  localparam int CW = (FS_DIV > 1) ? $clog2(FS_DIV) : 1;

  logic [CW-1:0] div_q, div_d;
  logic          stb;
  logic          prev_q, prev_d;
  logic          se0_now, k_now;

  always_comb begin
    se0_now = !line_dp && !line_dm;
    k_now   = !line_dp && line_dm;
    stb     = 1'b1;
    div_d   = '0;
    if (fs_sel) begin
      stb   = (div_q == CW'(FS_DIV - 1));
      div_d = stb ? '0 : div_q + 1'b1;
    end
    prev_d = prev_q;
    if (stb) prev_d = se0_now ? 1'b1 : line_dp;
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      div_q  <= '0;
      prev_q <= 1'b1;
      o_vld  <= 1'b0;
      o_bit  <= 1'b0;
      o_se0  <= 1'b0;
      o_k    <= 1'b0;
    end else begin
      div_q  <= div_d;
      prev_q <= prev_d;
      o_vld  <= stb;
      o_bit  <= (line_dp == prev_q);
      o_se0  <= se0_now;
      o_k    <= k_now;
    end
  end

  generate
    if (FS_DIV > 1) begin : g_fs_chk
      // R8: in full-speed mode two samples are never taken on adjacent cycles
      a_r8_fs_spacing: assert property (@(posedge fclk) disable iff (!frst_n)
        (stb && fs_sel) |=> !(stb && fs_sel));
    end
  endgenerate

endmodule

// File: rtl/usbrx_unstuff.sv
module usbrx_unstuff #(
  parameter int STUFF_RUN = 6
) (
  input  logic fclk,
  input  logic frst_n,
  input  logic arm,
  input  logic i_vld,
  input  logic i_bit,
  input  logic i_se0,
  input  logic i_k,
  output logic o_vld,
  output logic o_bit,
  output logic o_se0,
  output logic o_k,
  output logic o_err
);

  localparam int CW = $clog2(STUFF_RUN + 1);
  localparam int RW = $clog2(STUFF_RUN + 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          vld_d, bit_d, se0_d, k_d, err_d;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = 1'b0;
    bit_d = 1'b0;
    se0_d = 1'b0;
    k_d   = 1'b0;
    err_d = 1'b0;
    if (i_vld) begin
      if (i_se0) begin
        se0_d = 1'b1;
        cnt_d = '0;
      end else if (arm && (cnt_q == CW'(STUFF_RUN))) begin
        err_d = i_bit;
        cnt_d = '0;
      end else begin
        vld_d = 1'b1;
        bit_d = i_bit;
        k_d   = i_k;
        if (!i_bit)                          cnt_d = '0;
        else if (cnt_q != CW'(STUFF_RUN))    cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      cnt_q <= '0;
      o_vld <= 1'b0;
      o_bit <= 1'b0;
      o_se0 <= 1'b0;
      o_k   <= 1'b0;
      o_err <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      o_vld <= vld_d;
      o_bit <= bit_d;
      o_se0 <= se0_d;
      o_k   <= k_d;
      o_err <= err_d;
    end
  end

  // Checker: independent count of the raw run of decoded ones
  logic [RW-1:0] in_run_q;
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n)                       in_run_q <= '0;
    else if (i_vld && (i_se0 || !i_bit)) in_run_q <= '0;
    else if (i_vld && in_run_q <= RW'(STUFF_RUN)) in_run_q <= in_run_q + 1'b1;
  end

  // R5: the bit after a full run of ones never reaches the shift register
  a_r5_stuff_dropped: assert property (@(posedge fclk) disable iff (!frst_n)
    (i_vld && arm && !i_se0 && in_run_q == RW'(STUFF_RUN)) |=> !o_vld);

endmodule

// File: rtl/usbrx_assemble.sv
module usbrx_assemble
  import usbrx_pkg::*;
#(
  parameter int SYNC_ZEROS = 3
) (
  input  logic fclk,
  input  logic frst_n,
  input  logic i_vld,
  input  logic i_bit,
  input  logic i_se0,
  input  logic i_k,
  input  logic i_err,
  output logic arm,
  output logic ev_push,
  output ev_t  ev_out
);

  typedef enum logic [1:0] {S_HUNT, S_RECV, S_DRAIN} st_e;

  localparam int NBW = $clog2(BYTE_W);

  st_e                   st_q, st_d;
  logic [SYNC_ZEROS-1:0] hist_q, hist_d;
  logic [BYTE_W-1:0]     sh_q, sh_d;
  logic [NBW-1:0]        nb_q, nb_d;
  logic                  push_d;
  ev_t                   ev_d;
  logic [BYTE_W-1:0]     sh_next;

  always_comb begin
    st_d    = st_q;
    hist_d  = hist_q;
    sh_d    = sh_q;
    nb_d    = nb_q;
    push_d  = 1'b0;
    ev_d    = ev_out;
    sh_next = {i_bit, sh_q[BYTE_W-1:1]};
    unique case (st_q)
      S_HUNT: begin
        if (i_se0) begin
          hist_d = '1;
        end else if (i_vld) begin
          if (i_bit && i_k && hist_q == '0) begin
            st_d      = S_RECV;
            nb_d      = '0;
            push_d    = 1'b1;
            ev_d.kind = EV_SOP;
            ev_d.data = '0;
          end
          hist_d = {hist_q[SYNC_ZEROS-2:0], i_bit};
        end
      end
      S_RECV: begin
        if (i_se0) begin
          st_d      = S_HUNT;
          hist_d    = '1;
          push_d    = 1'b1;
          ev_d.kind = EV_EOP;
          ev_d.data = '0;
        end else if (i_err) begin
          st_d      = S_DRAIN;
          push_d    = 1'b1;
          ev_d.kind = EV_ERR;
          ev_d.data = '0;
        end else if (i_vld) begin
          sh_d = sh_next;
          nb_d = nb_q + 1'b1;
          if (nb_q == NBW'(BYTE_W - 1)) begin
            push_d    = 1'b1;
            ev_d.kind = EV_DATA;
            ev_d.data = sh_next;
          end
        end
      end
      default: begin
        if (i_se0) begin
          st_d   = S_HUNT;
          hist_d = '1;
        end
      end
    endcase
  end

  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) begin
      st_q    <= S_HUNT;
      hist_q  <= '1;
      sh_q    <= '0;
      nb_q    <= '0;
      ev_push <= 1'b0;
      ev_out  <= '0;
    end else begin
      st_q    <= st_d;
      hist_q  <= hist_d;
      sh_q    <= sh_d;
      nb_q    <= nb_d;
      ev_push <= push_d;
      ev_out  <= ev_d;
    end
  end

  assign arm = (st_q == S_RECV);

  // Checker: tracks whether a start event is open
  logic open_q;
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) open_q <= 1'b0;
    else if (ev_push && ev_out.kind == EV_SOP) open_q <= 1'b1;
    else if (ev_push && (ev_out.kind == EV_EOP || ev_out.kind == EV_ERR)) open_q <= 1'b0;
  end

  // R3: a byte event only follows a start event
  a_r3_data_inside_packet: assert property (@(posedge fclk) disable iff (!frst_n)
    (ev_push && ev_out.kind == EV_DATA) |-> open_q);

  // R6: an error event only closes an open packet
  a_r6_err_inside_packet: assert property (@(posedge fclk) disable iff (!frst_n)
    (ev_push && ev_out.kind == EV_ERR) |-> open_q);

endmodule

// File: rtl/usbrx_evq.sv
module usbrx_evq #(
  parameter int W     = 10,
  parameter int DEPTH = 8
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rclk,
  input  logic         rrst_n,
  output logic         rd_vld,
  output logic [W-1:0] rd_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin_q, wbin_d, wgray_q;
  logic [PW-1:0] rg_s1, rg_s2, rbin_w;
  logic          full, wr_ok;

  always_comb begin
    rbin_w = from_gray(rg_s2);
    full   = (wbin_q[AW] != rbin_w[AW]) && (wbin_q[AW-1:0] == rbin_w[AW-1:0]);
    wr_ok  = wr_en && !full;
    wbin_d = wr_ok ? wbin_q + 1'b1 : wbin_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_s1   <= '0;
      rg_s2   <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= to_gray(wbin_d);
      rg_s1   <= rgray_q;
      rg_s2   <= rg_s1;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wr_data;
  end

  // read domain
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic [PW-1:0] wg_s1, wg_s2, wbin_r;
  logic          empty;

  always_comb begin
    wbin_r = from_gray(wg_s2);
    empty  = (rbin_q == wbin_r);
    rbin_d = empty ? rbin_q : rbin_q + 1'b1;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_s1   <= '0;
      wg_s2   <= '0;
      rd_vld  <= 1'b0;
      rd_data <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= to_gray(rbin_d);
      wg_s1   <= wgray_q;
      wg_s2   <= wg_s1;
      rd_vld  <= !empty;
      if (!empty) rd_data <= mem[rbin_q[AW-1:0]];
    end
  end

  // R11: the serial side never offers an event to a full queue
  a_r11_no_overflow: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_en |-> !full);

endmodule

// File: rtl/usbrx_deser.sv
module usbrx_deser
  import usbrx_pkg::*;
#(
  parameter int FS_DIV     = 40,
  parameter int FIFO_DEPTH = 8,
  parameter int STUFF_RUN  = 6,
  parameter int SYNC_ZEROS = 3
) (
  input  logic              fclk,
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dp,
  input  logic              line_dm,
  input  logic              fs_sel,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_active,
  output logic              rx_error,
  output logic [1:0]        line_state
);

  // reset release per domain
  logic [1:0] frst_q, srst_q;
  logic       frst_n, srst_n;

  always_ff @(posedge fclk or negedge rst_n) begin
    if (!rst_n) frst_q <= '0;
    else        frst_q <= {frst_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= '0;
    else        srst_q <= {srst_q[0], 1'b1};
  end

  assign frst_n = frst_q[1];
  assign srst_n = srst_q[1];

  // mode select into the serial domain
  logic [1:0] fs_q;
  always_ff @(posedge fclk or negedge frst_n) begin
    if (!frst_n) fs_q <= '0;
    else         fs_q <= {fs_q[0], fs_sel};
  end

  // serial chain
  logic n_vld, n_bit, n_se0, n_k;
  logic u_vld, u_bit, u_se0, u_k, u_err;
  logic arm, ev_push;
  ev_t  ev_w;

  usbrx_nrzi #(.FS_DIV(FS_DIV)) u_nrzi (
    .fclk(fclk), .frst_n(frst_n), .line_dp(line_dp), .line_dm(line_dm),
    .fs_sel(fs_q[1]), .o_vld(n_vld), .o_bit(n_bit), .o_se0(n_se0), .o_k(n_k)
  );

  usbrx_unstuff #(.STUFF_RUN(STUFF_RUN)) u_unstuff (
    .fclk(fclk), .frst_n(frst_n), .arm(arm),
    .i_vld(n_vld), .i_bit(n_bit), .i_se0(n_se0), .i_k(n_k),
    .o_vld(u_vld), .o_bit(u_bit), .o_se0(u_se0), .o_k(u_k), .o_err(u_err)
  );

  usbrx_assemble #(.SYNC_ZEROS(SYNC_ZEROS)) u_assemble (
    .fclk(fclk), .frst_n(frst_n),
    .i_vld(u_vld), .i_bit(u_bit), .i_se0(u_se0), .i_k(u_k), .i_err(u_err),
    .arm(arm), .ev_push(ev_push), .ev_out(ev_w)
  );

  // crossing
  logic            q_vld;
  logic [EV_W-1:0] q_word;
  ev_t             q_ev;

  usbrx_evq #(.W(EV_W), .DEPTH(FIFO_DEPTH)) u_evq (
    .wclk(fclk), .wrst_n(frst_n), .wr_en(ev_push), .wr_data(ev_w),
    .rclk(clk), .rrst_n(srst_n), .rd_vld(q_vld), .rd_data(q_word)
  );

  assign q_ev = q_word;

  // UTMI-side outputs
  logic              valid_d, error_d, active_d;
  logic [BYTE_W-1:0] data_d;

  always_comb begin
    valid_d  = q_vld && (q_ev.kind == EV_DATA);
    error_d  = q_vld && (q_ev.kind == EV_ERR);
    active_d = rx_active;
    data_d   = rx_data;
    if (q_vld) begin
      unique case (q_ev.kind)
        EV_SOP:  active_d = 1'b1;
        EV_DATA: data_d   = q_ev.data;
        default: active_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rx_valid  <= 1'b0;
      rx_error  <= 1'b0;
      rx_active <= 1'b0;
      rx_data   <= '0;
    end else begin
      rx_valid  <= valid_d;
      rx_error  <= error_d;
      rx_active <= active_d;
      rx_data   <= data_d;
    end
  end

  // line state, two flip-flops
  logic [1:0] ls_s1;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ls_s1      <= '0;
      line_state <= '0;
    end else begin
      ls_s1      <= {line_dm, line_dp};
      line_state <= ls_s1;
    end
  end

  // R10: no byte strobe outside a packet
  a_r10_valid_in_packet: assert property (@(posedge clk) disable iff (!srst_n)
    rx_valid |-> rx_active);

  // R6: an error strobe coincides with the packet closing
  a_r6_error_closes: assert property (@(posedge clk) disable iff (!srst_n)
    rx_error |-> (!rx_active && $past(rx_active)));

  // R4: a byte strobe never overlaps an error strobe
  a_r4_valid_not_error: assert property (@(posedge clk) disable iff (!srst_n)
    $onehot0({rx_valid, rx_error}));

endmodule

// File: tb/usbrx_deser_test.sv
`timescale 1ns/1ps
module usbrx_deser_test;

  localparam int FS_DIV_TB = 12;

  logic       fclk = 1'b0;
  logic       clk  = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_dp = 1'b0;
  logic       line_dm = 1'b0;
  logic       fs_sel = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_active, rx_error;
  logic [1:0] line_state;

  always #1.25 fclk = ~fclk;
  always #10   clk  = ~clk;

  usbrx_deser #(.FS_DIV(FS_DIV_TB)) uut (
    .fclk(fclk), .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
    .fs_sel(fs_sel), .rx_data(rx_data), .rx_valid(rx_valid), .rx_active(rx_active),
    .rx_error(rx_error), .line_state(line_state)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor on the falling slow edge
  logic [7:0] got[$];
  int  err_cnt = 0, rise_cnt = 0, bad_valid = 0;
  bit  act_prev = 1'b0;

  always @(negedge clk) begin
    if (rx_valid) got.push_back(rx_data);
    if (rx_error) err_cnt++;
    if (rx_valid && !rx_active) bad_valid++;
    if (rx_active && !act_prev) rise_cnt++;
    act_prev = rx_active;
  end

  // line encoder
  bit cur_dp = 1'b1;
  int ones   = 0;

  task automatic drive_lv(input bit dp, input bit dm);
    line_dp = dp;
    line_dm = dm;
    repeat (fs_sel ? FS_DIV_TB : 1) @(negedge fclk);
  endtask

  task automatic send_dec(input bit b);
    if (!b) cur_dp = ~cur_dp;
    drive_lv(cur_dp, ~cur_dp);
  endtask

  task automatic send_sync();
    for (int i = 0; i < 7; i++) send_dec(1'b0);
    send_dec(1'b1);
    ones = 1;
  endtask

  task automatic send_data_bit(input bit b);
    send_dec(b);
    if (b) begin
      ones++;
      if (ones == 6) begin
        send_dec(1'b0);
        ones = 0;
      end
    end else begin
      ones = 0;
    end
  endtask

  task automatic send_eop();
    drive_lv(1'b0, 1'b0);
    drive_lv(1'b0, 1'b0);
    cur_dp = 1'b1;
    for (int i = 0; i < 10; i++) drive_lv(1'b1, 1'b0);
  endtask

  task automatic send_packet(input logic [7:0] bytes[$], input int extra);
    send_sync();
    foreach (bytes[i])
      for (int j = 0; j < 8; j++) send_data_bit(bytes[i][j]);
    for (int i = 0; i < extra; i++) send_data_bit(i[0]);
    send_eop();
  endtask

  task automatic clear_mon();
    got.delete();
    err_cnt  = 0;
    rise_cnt = 0;
  endtask

  task automatic run_pkt(input string req, input logic [7:0] bytes[$], input int extra);
    clear_mon();
    send_packet(bytes, extra);
    repeat (30) @(negedge clk);
    chk(got.size() == bytes.size(), req, "byte count", got.size(), bytes.size());
    for (int i = 0; i < bytes.size() && i < got.size(); i++)
      chk(got[i] == bytes[i], req, $sformatf("byte %0d", i), got[i], bytes[i]);
    chk(rise_cnt == 1, req, "rx_active rises", rise_cnt, 1);
    chk(err_cnt == 0, req, "rx_error pulses", err_cnt, 0);
    chk(rx_active == 1'b0, req, "rx_active after end", rx_active, 0);
  endtask

  function automatic logic [7:0] rand_byte();
    logic [31:0] r = $urandom;
    return (r[31:30] == 2'b00) ? 8'hFF : r[7:0];
  endfunction

  task automatic check_ls(input bit dp, input bit dm, input logic [1:0] exp);
    line_dp = dp;
    line_dm = dm;
    repeat (3) @(negedge clk);
    chk(line_state == exp, "R1", "line_state", line_state, exp);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL all watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] pkt[$];
    void'($urandom(32'd4242));

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(rx_active == 1'b0, "R9", "reset rx_active", rx_active, 0);
    chk(rx_valid == 1'b0, "R9", "reset rx_valid", rx_valid, 0);
    chk(rx_error == 1'b0, "R9", "reset rx_error", rx_error, 0);
    chk(line_state == 2'b00, "R9", "reset line_state", line_state, 0);
    line_dp = 1'b1;
    line_dm = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge fclk);

    // R1: line state encodings
    check_ls(1'b1, 1'b0, 2'b01);
    check_ls(1'b0, 1'b1, 2'b10);
    check_ls(1'b0, 1'b0, 2'b00);
    check_ls(1'b1, 1'b1, 2'b11);
    line_dp = 1'b1;
    line_dm = 1'b0;
    cur_dp  = 1'b1;
    repeat (3) @(negedge clk);
    @(negedge fclk);

    // R2 R3 R4: directed high-speed packet
    pkt = '{8'hA5, 8'h3C, 8'h00};
    run_pkt("R2", pkt, 0);

    // R5: stuffing-heavy bytes
    pkt = '{8'hFF, 8'hFF, 8'h7E, 8'hFE};
    run_pkt("R5", pkt, 0);

    // R7: trailing partial byte discarded
    pkt = '{8'h5A};
    run_pkt("R7", pkt, 5);

    // R6: stuff violation, drained bits, then recovery
    clear_mon();
    send_sync();
    for (int i = 0; i < 8; i++) send_dec(1'b1);
    for (int i = 0; i < 20; i++) send_dec(i[0]);
    send_eop();
    repeat (30) @(negedge clk);
    chk(err_cnt == 1, "R6", "rx_error pulses", err_cnt, 1);
    chk(got.size() == 0, "R6", "bytes after violation", got.size(), 0);
    chk(rx_active == 1'b0, "R6", "rx_active after violation", rx_active, 0);
    pkt = '{8'h81, 8'h42};
    run_pkt("R6", pkt, 0);

    // R11: long back-to-back high-speed packet and random packets
    pkt.delete();
    for (int i = 0; i < 24; i++) pkt.push_back(rand_byte());
    run_pkt("R11", pkt, 0);
    for (int n = 0; n < 8; n++) begin
      pkt.delete();
      for (int i = 0; i < 1 + ($urandom % 6); i++) pkt.push_back(rand_byte());
      run_pkt("R4", pkt, $urandom % 8);
    end

    // R8: full-speed mode
    fs_sel = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge fclk);
    pkt = '{8'hFF, 8'hC3};
    run_pkt("R8", pkt, 0);
    for (int n = 0; n < 2; n++) begin
      pkt.delete();
      for (int i = 0; i < 1 + ($urandom % 3); i++) pkt.push_back(rand_byte());
      run_pkt("R8", pkt, 3);
    end
    fs_sel = 1'b0;
    repeat (4) @(negedge clk);
    @(negedge fclk);

    // R9: reset in the middle of a packet
    clear_mon();
    pkt.delete();
    for (int i = 0; i < 10; i++) pkt.push_back(8'h11 * i[7:0]);
    fork
      send_packet(pkt, 0);
      begin
        while (got.size() < 2) @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        chk(rx_active == 1'b0, "R9", "rx_active in reset", rx_active, 0);
        chk(line_state == 2'b00, "R9", "line_state in reset", line_state, 0);
      end
    join
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge fclk);
    cur_dp = 1'b1;
    pkt = '{8'h96, 8'h69};
    run_pkt("R9", pkt, 0);

    // R10: no byte strobe seen outside a packet
    chk(bad_valid == 0, "R10", "rx_valid without rx_active", bad_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule